// File: doc/BRIEF.md
# Passive-Matrix Panel Line Timer

This block produces the timing of one horizontal line for a passive-matrix (STN) LCD panel. It runs from the fast system clock. Each line starts with a line-latch pulse. A selectable delay follows, then a burst of pixel shift-clock pulses, and finally a programmable blank interval in which the shift clock is idle. The blank interval trims the line rate in steps of 8 system clocks. A one-cycle strobe marks the end of every line. When enable stays high, the next line starts on the cycle after that strobe.

A single enumerated state machine steps through the states `ST_IDLE`, `ST_LATCH`, `ST_DELAY`, `ST_ACTIVE`, `ST_BLANK` and `ST_DONE`. The transitions are:

- `ST_IDLE` to `ST_LATCH` when enable is high.
- `ST_LATCH` to `ST_DELAY` when the latch segment expires.
- `ST_DELAY` to `ST_ACTIVE` when the delay segment expires.
- `ST_ACTIVE` to `ST_BLANK` after the last pixel pulse, or to `ST_DONE` directly when the blank count is zero.
- `ST_BLANK` to `ST_DONE` when the blank segment expires.
- `ST_DONE` to `ST_LATCH` if enable is still high, otherwise to `ST_IDLE`.

The configuration is captured on the edge that enters `ST_LATCH`. The check of the inter-line gap against a programmed minimum is made on that same edge.

Top module: `stn_line_timer`

## Requirements
- R1: A synchronous reset clears all state. After reset, and for as long as enable stays low, vline, vclk, data_req, line_done and config_error remain low.
- R2: Each line begins with vline high for cfg_latch_w+1 consecutive clock cycles.
- R3: From the first cycle with vline low to the first cycle with vclk high there are 16·(cfg_dly_sel+1) clock cycles. The codes 0, 1, 2 and 3 give 16, 32, 48 and 64 cycles. vclk stays low while vline is high and during this delay.
- R4: A line carries exactly cfg_hsize+1 vclk pulses. Each pulse is high for cfg_div+1 cycles and then low for cfg_div+1 cycles, with the high half first.
- R5: data_req is high for exactly one cycle per vclk pulse: the first cycle in which that pulse is high.
- R6: After the low half of the last pulse, vclk stays low for 8·cfg_blank further cycles before line_done. A value of zero adds no blank cycles.
- R7: line_done is high for one cycle after the blank interval. A full line lasts (cfg_latch_w+1) + 16·(cfg_dly_sel+1) + 2·(cfg_div+1)·(cfg_hsize+1) + 8·cfg_blank + 1 cycles, and with enable high the next vline follows immediately.
- R8: Configuration inputs are sampled only at the start of a line. Changing them during a line leaves that line unchanged, and the next line uses the new values.
- R9: config_error goes high when a line starts with 8·cfg_blank + (cfg_latch_w+1) + 16·(cfg_dly_sel+1) less than cfg_min_gap. It stays high until reset.
- R10: If enable is low when a line ends, the block idles with vline and vclk low. Dropping enable in mid-line lets that line finish normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run line generation |
| cfg_dly_sel | input | 2 | Latch-to-pixel delay code (16·(code+1) cycles) |
| cfg_blank | input | BLANK_W | Blank interval in units of 8 cycles |
| cfg_hsize | input | HSIZE_W | Pixel pulses per line minus one |
| cfg_latch_w | input | LATCH_W | Latch pulse width minus one |
| cfg_div | input | DIV_W | Half-period of vclk minus one |
| cfg_min_gap | input | GAP_W | Minimum inter-line gap in cycles |
| vline | output | 1 | Line-latch pulse |
| vclk | output | 1 | Pixel shift clock |
| data_req | output | 1 | Per-pulse data request strobe |
| line_done | output | 1 | End-of-line strobe |
| config_error | output | 1 | Sticky gap-rule violation flag |

## Verification
The assertions check the following on every cycle:
- vclk is never high together with vline or line_done.
- data_req coincides exactly with each rising vclk edge.
- line_done lasts one cycle.
- config_error never falls without a reset.
- The outputs are quiet right after reset.

Segment lengths, pulse counts, total line length, the mid-line configuration change, the enable drop and the gap-rule arithmetic cannot be seen from one cycle. Only the bench's measured lines, compared against formulas, show them.

// File: rtl/stn_line_pkg.sv
package stn_line_pkg;

    localparam int DELAY_SHIFT = 4;
    localparam int BLANK_SHIFT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_DELAY,
        ST_ACTIVE,
        ST_BLANK,
        ST_DONE
    } line_state_e;

    // Delay code to cycle count: 16 * (code + 1)
    function automatic logic [6:0] delay_len(input logic [1:0] sel);
        return ({5'd0, sel} + 7'd1) << DELAY_SHIFT;
    endfunction

endpackage

// File: rtl/stn_cfg_shadow.sv
module stn_cfg_shadow
    import stn_line_pkg::*;
#(
    parameter int HSIZE_W = 11,
    parameter int BLANK_W = 8,
    parameter int LATCH_W = 8,
    parameter int DIV_W   = 4,
    parameter int GAP_W   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample,
    input  logic [1:0]         cfg_dly_sel,
    input  logic [BLANK_W-1:0] cfg_blank,
    input  logic [HSIZE_W-1:0] cfg_hsize,
    input  logic [LATCH_W-1:0] cfg_latch_w,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [GAP_W-1:0]   cfg_min_gap,
    output logic [1:0]         sh_dly_sel,
    output logic [BLANK_W-1:0] sh_blank,
    output logic [HSIZE_W-1:0] sh_hsize,
    output logic [DIV_W-1:0]   sh_div,
    output logic               gap_err
);

    localparam int SUM_A = (BLANK_W + BLANK_SHIFT > LATCH_W + 1) ? BLANK_W + BLANK_SHIFT : LATCH_W + 1;
    localparam int SUM_W = ((SUM_A > 7) ? SUM_A : 7) + 2;
    localparam int CMP_W = (SUM_W > GAP_W) ? SUM_W : GAP_W;

    logic [CMP_W-1:0] gap_sum;
    logic [CMP_W-1:0] gap_min;

    always_comb begin
        gap_sum = (CMP_W'(cfg_blank) << BLANK_SHIFT)
                + CMP_W'(cfg_latch_w) + CMP_W'(1)
                + CMP_W'(delay_len(cfg_dly_sel));
        gap_min = CMP_W'(cfg_min_gap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_dly_sel <= '0;
            sh_blank   <= '0;
            sh_hsize   <= '0;
            sh_div     <= '0;
            gap_err    <= 1'b0;
        end else if (sample) begin
            sh_dly_sel <= cfg_dly_sel;
            sh_blank   <= cfg_blank;
            sh_hsize   <= cfg_hsize;
            sh_div     <= cfg_div;
            if (gap_sum < gap_min) begin
                gap_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/stn_seg_counter.sv
module stn_seg_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/stn_vclk_gen.sv
module stn_vclk_gen #(
    parameter int HSIZE_W = 11,
    parameter int DIV_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               run,
    input  logic [DIV_W-1:0]   div,
    input  logic [HSIZE_W-1:0] hsize,
    output logic               vclk,
    output logic               req,
    output logic               last
);

    localparam int PH_W = DIV_W + 1;

    logic [PH_W-1:0]    ph_q;
    logic [HSIZE_W-1:0] pc_q;
    logic               period_end;

    assign period_end = (ph_q == {div, 1'b1});

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
            pc_q <= '0;
        end else if (start) begin
            ph_q <= '0;
            pc_q <= '0;
        end else if (run) begin
            if (period_end) begin
                ph_q <= '0;
                pc_q <= pc_q + HSIZE_W'(1);
            end else begin
                ph_q <= ph_q + PH_W'(1);
            end
        end
    end

    assign vclk = run && (ph_q <= {1'b0, div});
    assign req  = run && (ph_q == '0);
    assign last = run && period_end && (pc_q == hsize);

endmodule

// File: rtl/stn_line_timer.sv
module stn_line_timer
    import stn_line_pkg::*;
#(
    parameter int HSIZE_W = 11,
    parameter int BLANK_W = 8,
    parameter int LATCH_W = 8,
    parameter int DIV_W   = 4,
    parameter int GAP_W   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [1:0]         cfg_dly_sel,
    input  logic [BLANK_W-1:0] cfg_blank,
    input  logic [HSIZE_W-1:0] cfg_hsize,
    input  logic [LATCH_W-1:0] cfg_latch_w,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [GAP_W-1:0]   cfg_min_gap,
    output logic               vline,
    output logic               vclk,
    output logic               data_req,
    output logic               line_done,
    output logic               config_error
);

    localparam int SEG_A = (LATCH_W > BLANK_W + BLANK_SHIFT) ? LATCH_W : BLANK_W + BLANK_SHIFT;
    localparam int SEG_W = (SEG_A > 7) ? SEG_A : 7;

    line_state_e        state_q;
    line_state_e        state_d;
    logic               sample;
    logic               seg_load;
    logic [SEG_W-1:0]   seg_val;
    logic               seg_expired;
    logic               pix_start;
    logic               pix_run;
    logic               pix_vclk;
    logic               pix_req;
    logic               pix_last;
    logic [1:0]         sh_dly_sel;
    logic [BLANK_W-1:0] sh_blank;
    logic [HSIZE_W-1:0] sh_hsize;
    logic [DIV_W-1:0]   sh_div;
    logic               gap_err;

    stn_cfg_shadow #(
        .HSIZE_W(HSIZE_W), .BLANK_W(BLANK_W), .LATCH_W(LATCH_W),
        .DIV_W(DIV_W), .GAP_W(GAP_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .sample(sample),
        .cfg_dly_sel(cfg_dly_sel), .cfg_blank(cfg_blank), .cfg_hsize(cfg_hsize),
        .cfg_latch_w(cfg_latch_w), .cfg_div(cfg_div), .cfg_min_gap(cfg_min_gap),
        .sh_dly_sel(sh_dly_sel), .sh_blank(sh_blank), .sh_hsize(sh_hsize),
        .sh_div(sh_div), .gap_err(gap_err)
    );

    stn_seg_counter #(.CNT_W(SEG_W)) u_seg (
        .clk(clk), .rst(rst), .load(seg_load), .load_val(seg_val),
        .expired(seg_expired)
    );

    stn_vclk_gen #(.HSIZE_W(HSIZE_W), .DIV_W(DIV_W)) u_pix (
        .clk(clk), .rst(rst), .start(pix_start), .run(pix_run),
        .div(sh_div), .hsize(sh_hsize),
        .vclk(pix_vclk), .req(pix_req), .last(pix_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and segment control
    always_comb begin
        state_d   = state_q;
        sample    = 1'b0;
        seg_load  = 1'b0;
        seg_val   = '0;
        pix_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) begin
                    sample   = 1'b1;
                    seg_load = 1'b1;
                    seg_val  = SEG_W'(cfg_latch_w);
                    state_d  = ST_LATCH;
                end
            end
            ST_LATCH: begin
                if (seg_expired) begin
                    seg_load = 1'b1;
                    seg_val  = SEG_W'(delay_len(sh_dly_sel)) - SEG_W'(1);
                    state_d  = ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (seg_expired) begin
                    pix_start = 1'b1;
                    state_d   = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (pix_last) begin
                    if (sh_blank != '0) begin
                        seg_load = 1'b1;
                        seg_val  = (SEG_W'(sh_blank) << BLANK_SHIFT) - SEG_W'(1);
                        state_d  = ST_BLANK;
                    end else begin
                        state_d  = ST_DONE;
                    end
                end
            end
            ST_BLANK: begin
                if (seg_expired) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (enable) begin
                    sample   = 1'b1;
                    seg_load = 1'b1;
                    seg_val  = SEG_W'(cfg_latch_w);
                    state_d  = ST_LATCH;
                end else begin
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pix_run      = (state_q == ST_ACTIVE);
        vline        = (state_q == ST_LATCH);
        line_done    = (state_q == ST_DONE);
        vclk         = pix_vclk;
        data_req     = pix_req;
        config_error = gap_err;
    end

endmodule

// File: rtl/stn_line_timer_chk.sv
module stn_line_timer_chk (
    input logic clk,
    input logic rst,
    input logic vline,
    input logic vclk,
    input logic data_req,
    input logic line_done,
    input logic config_error
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!vline && !vclk && !data_req && !line_done && !config_error)); // R1

    AST_LATCH_NO_VCLK: assert property (@(posedge clk) disable iff (rst)
        vline |-> !vclk); // R3

    AST_REQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        data_req |-> (vclk && !$past(vclk))); // R5

    AST_RISE_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(vclk) |-> data_req); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        line_done |-> (!vclk && !vline)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !line_done); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        config_error |=> config_error); // R9

endmodule

bind stn_line_timer stn_line_timer_chk u_chk (
    .clk(clk), .rst(rst), .vline(vline), .vclk(vclk),
    .data_req(data_req), .line_done(line_done), .config_error(config_error)
);

// File: tb/stn_line_timer_test.sv
module stn_line_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    typedef struct packed {
        logic [1:0]  dly;
        logic [7:0]  blank;
        logic [10:0] hsize;
        logic [7:0]  latch;
        logic [3:0]  div;
        logic [11:0] mingap;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 8'd0,  11'd0, 8'd0, 4'd0, 12'd0},
        '{2'd1, 8'd2,  11'd3, 8'd2, 4'd1, 12'd0},
        '{2'd2, 8'd10, 11'd7, 8'd5, 4'd0, 12'd20},
        '{2'd3, 8'd1,  11'd4, 8'd1, 4'd3, 12'd0},
        '{2'd0, 8'd3,  11'd2, 8'd3, 4'd2, 12'd100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [1:0]  cfg_dly_sel = '0;
    logic [7:0]  cfg_blank = '0;
    logic [10:0] cfg_hsize = '0;
    logic [7:0]  cfg_latch_w = '0;
    logic [3:0]  cfg_div = '0;
    logic [11:0] cfg_min_gap = '0;
    logic        vline, vclk, data_req, line_done, config_error;

    int checks = 0;
    int errors = 0;
    int m_width, m_delay, m_pulses, m_high, m_reqs, m_tail, m_total;

    stn_line_timer uut (
        .clk(clk), .rst(rst), .enable(enable),
        .cfg_dly_sel(cfg_dly_sel), .cfg_blank(cfg_blank), .cfg_hsize(cfg_hsize),
        .cfg_latch_w(cfg_latch_w), .cfg_div(cfg_div), .cfg_min_gap(cfg_min_gap),
        .vline(vline), .vclk(vclk), .data_req(data_req),
        .line_done(line_done), .config_error(config_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cfg_dly_sel = v.dly;
        cfg_blank   = v.blank;
        cfg_hsize   = v.hsize;
        cfg_latch_w = v.latch;
        cfg_div     = v.div;
        cfg_min_gap = v.mingap;
    endtask

    function automatic bit gap_bad(input vec_t v);
        return (8*int'(v.blank) + int'(v.latch) + 1 + 16*(int'(v.dly) + 1)) < int'(v.mingap);
    endfunction

    // Measure one line; optionally change config or drop enable at first pulse
    task automatic measure(input bit disturb, input vec_t alt, input bit drop_en);
        bit prev_vclk = 1'b0;
        bit seen = 1'b0;
        m_width = 0; m_delay = 0; m_pulses = 0; m_high = 0;
        m_reqs = 0; m_tail = 0; m_total = 0;
        do @(negedge clk); while (!vline);
        forever begin
            m_total++;
            if (vline) m_width++;
            else if (!seen && !vclk) m_delay++;
            if (vclk && !prev_vclk) begin
                m_pulses++;
                seen = 1'b1;
                if (m_pulses == 1 && disturb) apply(alt);
                if (m_pulses == 1 && drop_en) enable = 1'b0;
            end
            if (vclk) begin
                m_high++;
                m_tail = 0;
            end else if (seen && !line_done) begin
                m_tail++;
            end
            if (data_req) m_reqs++;
            if (line_done) break;
            prev_vclk = vclk;
            @(negedge clk);
        end
    endtask

    task automatic verify(input vec_t v, input string tag);
        int d1 = int'(v.div) + 1;
        int p  = int'(v.hsize) + 1;
        check({"R2 ", tag}, "vline width", m_width, int'(v.latch) + 1);
        check({"R3 ", tag}, "delay", m_delay, 16*(int'(v.dly) + 1));
        check({"R4 ", tag}, "pulses", m_pulses, p);
        check({"R4 ", tag}, "high cycles", m_high, p*d1);
        check({"R5 ", tag}, "data_req count", m_reqs, p);
        check({"R6 ", tag}, "tail", m_tail, d1 + 8*int'(v.blank));
        check({"R7 ", tag}, "line length", m_total,
              int'(v.latch) + 1 + 16*(int'(v.dly) + 1) + 2*d1*p + 8*int'(v.blank) + 1);
    endtask

    task automatic quiet_check(input string req, input int n);
        int busy = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (vline || vclk || data_req || line_done) busy++;
        end
        check(req, "active cycles while idle", busy, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit exp_err = 1'b0;
        // R1: reset state with enable low
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "config_error after reset", int'(config_error), 0);
        quiet_check("R1", 20);

        // Vector table walk, lines back to back
        apply(VECS[0]);
        enable = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            measure(1'b0, VECS[0], 1'b0);
            verify(VECS[i], $sformatf("vec%0d", i));
            exp_err = exp_err | gap_bad(VECS[i]);
            check("R9", $sformatf("config_error vec%0d", i), int'(config_error), int'(exp_err));
        end
        // R9 sticky: a legal line keeps the flag set
        apply(VECS[0]);
        measure(1'b0, VECS[0], 1'b0);
        check("R9", "config_error sticky", int'(config_error), 1);

        // R1: reset in mid-run
        @(negedge clk);
        enable = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", "config_error cleared", int'(config_error), 0);
        quiet_check("R1", 10);

        // R8: change config in mid-line
        apply(VECS[1]);
        enable = 1'b1;
        measure(1'b1, VECS[2], 1'b0);
        verify(VECS[1], "R8 mid-line change ignored");
        measure(1'b0, VECS[0], 1'b1);
        verify(VECS[2], "R8 new config next line");

        // R10: enable dropped mid-line, line completed above, then idle
        quiet_check("R10", 60);
        check("R9", "no error on legal lines", int'(config_error), 0);

        // R10: enable low at line end
        apply(VECS[3]);
        enable = 1'b1;
        measure(1'b0, VECS[0], 1'b0);
        verify(VECS[3], "R10 restart");
        enable = 1'b0;
        quiet_check("R10", 40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule